// File: doc/BRIEF.md
# Two-Lane Halfband Decimating Downconverter

This block takes a wideband complex stream that arrives as two samples on every clock, shifts it in frequency by a programmable amount, and reduces its rate by eight. The result is a narrow single-lane stream suited to sync-block detection. Each clock carries one beat of two consecutive samples. Lane 0 holds the earlier sample and lane 1 the later one. At the nominal 245.76 MHz clock this is a 491.52 Msps input, and the output rate is 61.44 Msps.

A numerically controlled oscillator rotates both lanes before any filtering takes place. Three halfband decimate-by-two stages follow in cascade. The first stage folds the two lanes into one, so that it emits one sample per beat. The remaining stages work on a single lane whose valid signal grows sparser at each step. Every stage uses the same symmetric 11-tap halfband. The taps, in units of 1/32768, are 342, 0, -2100, 0, 9950, 16384, 9950, 0, -2100, 0, 342. They sum to exactly one. After the mixer and after every stage, the result is rounded to nearest and saturated back to the sample width.

Top module: `two_lane_hb_ddc`

## Requirements
- R1: While reset is high, and on the first clock after it falls, `out_valid` is 0 and both output words are 0.
- R2: On each accepted beat, lane 0 is rotated by exp(-j·2π·p/2^32) and lane 1 by exp(-j·2π·(p+f)/2^32). Here p is a 32-bit phase register that starts at 0 after reset and grows by 2·f on every accepted beat, and f is `freq_word`. The rotation angle is taken from the top 4 bits of the phase, and each amplitude is cos(2πk/16)·65536 rounded to nearest. The rotated result is rounded and then saturated.
- R3: With `freq_word` = 0 and a constant input on both lanes, the settled output equals that input exactly, because the overall gain at zero frequency is one.
- R4: In the first stage, lane 0 samples feed only the even tap positions and lane 1 samples feed only the centre tap. As a result, an input whose lanes carry +x and -x settles to an output of exactly 0.
- R5: With `in_valid` high on every clock, `out_valid` is high on exactly one clock in every four once the pipeline has filled.
- R6: Only beats with `in_valid` high are consumed. With `in_valid` high every other clock, outputs come one in eight clocks. With `in_valid` held low, no output is produced.
- R7: Each stage saturates rather than wraps. A full-scale constant settles to 32767 or -32768, and a full-scale step from negative to positive never produces a negative output after the first positive one.
- R8: The output words stay unchanged on every clock where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat qualifier |
| freq_word | input | 32 | Per-sample phase increment of the oscillator |
| in_re0 | input | 16 | Lane 0 (earlier sample) real part |
| in_im0 | input | 16 | Lane 0 imaginary part |
| in_re1 | input | 16 | Lane 1 (later sample) real part |
| in_im1 | input | 16 | Lane 1 imaginary part |
| out_valid | output | 1 | Output sample qualifier |
| out_re | output | 16 | Decimated output real part |
| out_im | output | 16 | Decimated output imaginary part |

## Verification
A constant input with a zero offset checks that the gain at zero frequency is one. It also confirms that the output is correct to the last bit. A lane-alternating sign pattern settles to zero only when each lane drives its correct polyphase taps. A constant input with a half-cycle offset gives the same null only when the lane 1 phase offset is correct. A tone sitting exactly at the oscillator frequency comes out as a constant real value, which separates a correct conjugate rotation from a wrong sign or a wrong phase step. Continuous, gapped and idle valid patterns show the rate behaviour. Full-scale constants and steps show that the stages saturate and do not wrap.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

    // Halfband taps, scaled by 2^TAP_FRAC; symmetric, even offsets from centre are zero
    localparam int TAP_FRAC = 15;
    localparam logic signed [17:0] TAP_MID = 18'sd16384;
    localparam logic signed [17:0] TAP_A   = 18'sd9950;   // offset +-1
    localparam logic signed [17:0] TAP_B   = -18'sd2100;  // offset +-3
    localparam logic signed [17:0] TAP_C   = 18'sd342;    // offset +-5

    // Oscillator amplitude format
    localparam int TRIG_FRAC = 16;
    localparam int TRIG_W    = 18;
    localparam int LUT_BITS  = 4;

    typedef struct packed {
        logic signed [TRIG_W-1:0] c;
        logic signed [TRIG_W-1:0] s;
    } trig_t;

    function automatic logic signed [TRIG_W-1:0] cos_lut(input logic [LUT_BITS-1:0] k);
        logic signed [TRIG_W-1:0] v;
        case (k)
            4'd0:  v = 18'sd65536;
            4'd1:  v = 18'sd60547;
            4'd2:  v = 18'sd46341;
            4'd3:  v = 18'sd25080;
            4'd4:  v = 18'sd0;
            4'd5:  v = -18'sd25080;
            4'd6:  v = -18'sd46341;
            4'd7:  v = -18'sd60547;
            4'd8:  v = -18'sd65536;
            4'd9:  v = -18'sd60547;
            4'd10: v = -18'sd46341;
            4'd11: v = -18'sd25080;
            4'd12: v = 18'sd0;
            4'd13: v = 18'sd25080;
            4'd14: v = 18'sd46341;
            default: v = 18'sd60547;
        endcase
        return v;
    endfunction

    function automatic trig_t trig_of(input logic [LUT_BITS-1:0] k);
        trig_t t;
        t.c = cos_lut(k);
        t.s = cos_lut(k - 4'd4);
        return t;
    endfunction

    // Round to nearest (half up) after an arithmetic right shift, then clamp to w bits
    function automatic longint round_sat(input longint v, input int sh, input int w);
        longint r;
        longint hi;
        longint lo;
        r  = (v + (longint'(1) <<< (sh - 1))) >>> sh;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -hi - 1;
        if (r > hi)      r = hi;
        else if (r < lo) r = lo;
        return r;
    endfunction

endpackage

// File: rtl/ddc_nco_mixer.sv
module ddc_nco_mixer #(
    parameter int W  = 16,
    parameter int PW = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [PW-1:0]       freq_word,
    input  logic signed [W-1:0] in_re0,
    input  logic signed [W-1:0] in_im0,
    input  logic signed [W-1:0] in_re1,
    input  logic signed [W-1:0] in_im1,
    output logic                out_valid,
    output logic signed [W-1:0] out_re0,
    output logic signed [W-1:0] out_im0,
    output logic signed [W-1:0] out_re1,
    output logic signed [W-1:0] out_im1
);
    import ddc_pkg::*;

    localparam int MW = W + TRIG_W + 2;

    logic [PW-1:0]       phase;
    logic [PW-1:0]       lane_ph [2];
    logic signed [W-1:0] x_re [2];
    logic signed [W-1:0] x_im [2];
    logic signed [W-1:0] y_re [2];
    logic signed [W-1:0] y_im [2];

    assign lane_ph[0] = phase;
    assign lane_ph[1] = phase + freq_word;
    assign x_re[0] = in_re0;
    assign x_im[0] = in_im0;
    assign x_re[1] = in_re1;
    assign x_im[1] = in_im1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) phase <= phase + {freq_word[PW-2:0], 1'b0};
        end
    end

    for (genvar L = 0; L < 2; L++) begin : g_lane
        trig_t                t;
        logic signed [MW-1:0] pr;
        logic signed [MW-1:0] pi;

        assign t  = trig_of(lane_ph[L][PW-1 -: LUT_BITS]);
        assign pr = MW'(x_re[L]) * MW'(t.c) + MW'(x_im[L]) * MW'(t.s);
        assign pi = MW'(x_im[L]) * MW'(t.c) - MW'(x_re[L]) * MW'(t.s);

        always_ff @(posedge clk) begin
            if (rst) begin
                y_re[L] <= '0;
                y_im[L] <= '0;
            end else if (in_valid) begin
                y_re[L] <= W'(round_sat(64'(pr), TRIG_FRAC, W));
                y_im[L] <= W'(round_sat(64'(pi), TRIG_FRAC, W));
            end
        end
    end

    assign out_re0 = y_re[0];
    assign out_im0 = y_im[0];
    assign out_re1 = y_re[1];
    assign out_im1 = y_im[1];

endmodule

// File: rtl/ddc_hb_fold.sv
module ddc_hb_fold #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_re0,
    input  logic signed [W-1:0] in_im0,
    input  logic signed [W-1:0] in_re1,
    input  logic signed [W-1:0] in_im1,
    output logic                out_valid,
    output logic signed [W-1:0] out_re,
    output logic signed [W-1:0] out_im
);
    import ddc_pkg::*;

    localparam int AW      = W + 22;
    localparam int EVEN_D  = 6;   // lane 0 history: taps 0,2,4,6,8,10
    localparam int ODD_D   = 4;   // lane 1 history: centre tap sees beat m-3

    logic                vd;
    logic signed [W-1:0] lane0 [2];
    logic signed [W-1:0] lane1 [2];
    logic signed [W-1:0] res   [2];

    assign lane0[0] = in_re0;
    assign lane0[1] = in_im0;
    assign lane1[0] = in_re1;
    assign lane1[1] = in_im1;

    always_ff @(posedge clk) begin
        if (rst) begin
            vd        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            vd        <= in_valid;
            out_valid <= vd;
        end
    end

    for (genvar C = 0; C < 2; C++) begin : g_comp
        logic signed [W-1:0]  ev [EVEN_D];
        logic signed [W-1:0]  od [ODD_D];
        logic signed [AW-1:0] acc;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < EVEN_D; i++) ev[i] <= '0;
                for (int i = 0; i < ODD_D; i++)  od[i] <= '0;
            end else if (in_valid) begin
                ev[0] <= lane0[C];
                od[0] <= lane1[C];
                for (int i = 1; i < EVEN_D; i++) ev[i] <= ev[i-1];
                for (int i = 1; i < ODD_D; i++)  od[i] <= od[i-1];
            end
        end

        assign acc = AW'(TAP_C) * (AW'(ev[0]) + AW'(ev[5]))
                   + AW'(TAP_B) * (AW'(ev[1]) + AW'(ev[4]))
                   + AW'(TAP_A) * (AW'(ev[2]) + AW'(ev[3]))
                   + AW'(TAP_MID) * AW'(od[ODD_D-1]);

        always_ff @(posedge clk) begin
            if (rst)     res[C] <= '0;
            else if (vd) res[C] <= W'(round_sat(64'(acc), TAP_FRAC, W));
        end
    end

    assign out_re = res[0];
    assign out_im = res[1];

endmodule

// File: rtl/ddc_hb_dec.sv
module ddc_hb_dec #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_re,
    input  logic signed [W-1:0] in_im,
    output logic                out_valid,
    output logic signed [W-1:0] out_re,
    output logic signed [W-1:0] out_im
);
    import ddc_pkg::*;

    localparam int AW   = W + 22;
    localparam int TAPS = 11;

    logic                keep;   // toggles on each accepted sample; every second one produces output
    logic                vd;
    logic signed [W-1:0] x   [2];
    logic signed [W-1:0] res [2];

    assign x[0] = in_re;
    assign x[1] = in_im;

    always_ff @(posedge clk) begin
        if (rst) begin
            keep      <= 1'b0;
            vd        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            vd        <= in_valid & keep;
            out_valid <= vd;
            if (in_valid) keep <= ~keep;
        end
    end

    for (genvar C = 0; C < 2; C++) begin : g_comp
        logic signed [W-1:0]  sr [TAPS];
        logic signed [AW-1:0] acc;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < TAPS; i++) sr[i] <= '0;
            end else if (in_valid) begin
                sr[0] <= x[C];
                for (int i = 1; i < TAPS; i++) sr[i] <= sr[i-1];
            end
        end

        assign acc = AW'(TAP_C) * (AW'(sr[0]) + AW'(sr[10]))
                   + AW'(TAP_B) * (AW'(sr[2]) + AW'(sr[8]))
                   + AW'(TAP_A) * (AW'(sr[4]) + AW'(sr[6]))
                   + AW'(TAP_MID) * AW'(sr[5]);

        always_ff @(posedge clk) begin
            if (rst)     res[C] <= '0;
            else if (vd) res[C] <= W'(round_sat(64'(acc), TAP_FRAC, W));
        end
    end

    assign out_re = res[0];
    assign out_im = res[1];

endmodule

// File: rtl/two_lane_hb_ddc.sv
module two_lane_hb_ddc #(
    parameter int W           = 16,
    parameter int PHASE_W     = 32,
    parameter int LATE_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [PHASE_W-1:0]    freq_word,
    input  logic signed [W-1:0]   in_re0,
    input  logic signed [W-1:0]   in_im0,
    input  logic signed [W-1:0]   in_re1,
    input  logic signed [W-1:0]   in_im1,
    output logic                  out_valid,
    output logic signed [W-1:0]   out_re,
    output logic signed [W-1:0]   out_im
);

    logic                mix_v;
    logic signed [W-1:0] mix_re0, mix_im0, mix_re1, mix_im1;
    logic                fold_v;

    logic [LATE_STAGES:0] st_v;
    logic signed [W-1:0]  st_re [LATE_STAGES+1];
    logic signed [W-1:0]  st_im [LATE_STAGES+1];

    ddc_nco_mixer #(.W(W), .PW(PHASE_W)) u_mix (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .freq_word (freq_word),
        .in_re0    (in_re0),
        .in_im0    (in_im0),
        .in_re1    (in_re1),
        .in_im1    (in_im1),
        .out_valid (mix_v),
        .out_re0   (mix_re0),
        .out_im0   (mix_im0),
        .out_re1   (mix_re1),
        .out_im1   (mix_im1)
    );

    ddc_hb_fold #(.W(W)) u_fold (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (mix_v),
        .in_re0    (mix_re0),
        .in_im0    (mix_im0),
        .in_re1    (mix_re1),
        .in_im1    (mix_im1),
        .out_valid (fold_v),
        .out_re    (st_re[0]),
        .out_im    (st_im[0])
    );

    assign st_v[0] = fold_v;

    for (genvar g = 0; g < LATE_STAGES; g++) begin : g_stage
        ddc_hb_dec #(.W(W)) u_dec (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (st_v[g]),
            .in_re     (st_re[g]),
            .in_im     (st_im[g]),
            .out_valid (st_v[g+1]),
            .out_re    (st_re[g+1]),
            .out_im    (st_im[g+1])
        );
    end

    assign out_valid = st_v[LATE_STAGES];
    assign out_re    = st_re[LATE_STAGES];
    assign out_im    = st_im[LATE_STAGES];

endmodule

// File: rtl/ddc_checker.sv
module ddc_checker #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                mix_valid,
    input logic                fold_valid,
    input logic                out_valid,
    input logic signed [W-1:0] out_re,
    input logic signed [W-1:0] out_im
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && out_re == '0 && out_im == '0));

    // R6: the mixer only emits for a beat that was accepted
    assert_mix_from_beat_R6: assert property (@(posedge clk) disable iff (rst)
        mix_valid |-> $past(in_valid));

    // R4: the folding stage produces at most one sample per mixed beat, two clocks later
    assert_fold_per_beat_R4: assert property (@(posedge clk) disable iff (rst)
        fold_valid |-> $past(mix_valid, 2));

    assert_sparse_output_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_re) && $stable(out_im)));

endmodule

bind two_lane_hb_ddc ddc_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .mix_valid  (mix_v),
    .fold_valid (fold_v),
    .out_valid  (out_valid),
    .out_re     (out_re),
    .out_im     (out_im)
);

// File: tb/two_lane_hb_ddc_test.sv
module two_lane_hb_ddc_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int WATCHDOG = 100000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [31:0]         freq_word = '0;
    logic signed [W-1:0] in_re0 = '0, in_im0 = '0, in_re1 = '0, in_im1 = '0;
    logic                out_valid;
    logic signed [W-1:0] out_re, out_im;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    two_lane_hb_ddc uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .freq_word(freq_word),
        .in_re0(in_re0), .in_im0(in_im0), .in_re1(in_re1), .in_im1(in_im1),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    task automatic check(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        in_re0 = '0; in_im0 = '0; in_re1 = '0; in_im1 = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    // Drive a constant beat for n clocks (valid every 'every' clocks); count outputs, keep last
    task automatic run_const(input int n, input int every, input int r0, input int i0,
                             input int r1, input int i1,
                             output int cnt, output int lr, output int li);
        cnt = 0; lr = int'(out_re); li = int'(out_im);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = (k % every) == 0;
            in_re0 = W'(r0); in_im0 = W'(i0); in_re1 = W'(r1); in_im1 = W'(i1);
            if (out_valid) begin
                cnt++; lr = int'(out_re); li = int'(out_im);
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", out_valid == 1'b0, int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", out_valid == 1'b0, int'(out_valid), 0);
        check("R1 re after reset", out_re == 0, int'(out_re), 0);
        check("R1 im after reset", out_im == 0, int'(out_im), 0);
    endtask

    task automatic t_dc_and_rate();
        int c, r, i;
        freq_word = 32'd0;
        do_reset();
        run_const(200, 1, 1000, -2000, 1000, -2000, c, r, i);
        check("R3 dc re", r == 1000, r, 1000);
        check("R3 dc im", i == -2000, i, -2000);
        run_const(64, 1, 1000, -2000, 1000, -2000, c, r, i);
        check("R5 one in four", c == 16, c, 16);
    endtask

    task automatic t_lane_alternate();
        int c, r, i;
        freq_word = 32'd0;
        do_reset();
        run_const(200, 1, 3000, 1500, -3000, -1500, c, r, i);
        check("R4 alternate re", r == 0, r, 0);
        check("R4 alternate im", i == 0, i, 0);
    endtask

    task automatic t_half_cycle_offset();
        int c, r, i;
        freq_word = 32'h8000_0000;  // lane 1 rotated by pi relative to lane 0
        do_reset();
        run_const(200, 1, 5000, 700, 5000, 700, c, r, i);
        check("R2 half-cycle re", r == 0, r, 0);
        check("R2 half-cycle im", i == 0, i, 0);
    endtask

    task automatic t_tone_mixdown();
        int r = 0, i = 0;
        real w;
        freq_word = 32'h1000_0000;  // 1/16 cycle per sample
        do_reset();
        w = 2.0 * 3.14159265358979 / 16.0;
        for (int m = 0; m < 300; m++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re0 = W'(int'(8000.0 * $cos(w * (2*m))));
            in_im0 = W'(int'(8000.0 * $sin(w * (2*m))));
            in_re1 = W'(int'(8000.0 * $cos(w * (2*m + 1))));
            in_im1 = W'(int'(8000.0 * $sin(w * (2*m + 1))));
            if (out_valid) begin r = int'(out_re); i = int'(out_im); end
        end
        check("R2 tone to dc re", r >= 7992 && r <= 8008, r, 8000);
        check("R2 tone to dc im", i >= -8 && i <= 8, i, 0);
    endtask

    task automatic t_gaps_and_idle();
        int c, r, i, r0, i0;
        bit held = 1'b1;
        freq_word = 32'd0;
        do_reset();
        run_const(300, 2, 1234, 55, 1234, 55, c, r, i);
        run_const(128, 2, 1234, 55, 1234, 55, c, r, i);
        check("R6 gapped one in eight", c == 16, c, 16);
        // let pending samples drain, then hold valid low
        @(negedge clk); in_valid = 1'b0;
        repeat (20) @(negedge clk);
        r0 = int'(out_re); i0 = int'(out_im);
        c = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            in_re0 = W'(-9000 + k); in_im0 = W'(k); in_re1 = W'(7000); in_im1 = W'(-k);
            if (out_valid) c++;
            if (int'(out_re) != r0 || int'(out_im) != i0) held = 1'b0;
        end
        check("R6 idle no output", c == 0, c, 0);
        check("R8 output held", held, int'(out_re), r0);
    endtask

    task automatic t_saturation();
        int c, r, i;
        bit seen_pos = 1'b0, wrapped = 1'b0;
        freq_word = 32'd0;
        do_reset();
        run_const(200, 1, -32768, 32767, -32768, 32767, c, r, i);
        check("R7 negative full scale", r == -32768, r, -32768);
        check("R7 positive full scale", i == 32767, i, 32767);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_re0 = 16'sh7fff; in_re1 = 16'sh7fff; in_im0 = '0; in_im1 = '0;
            if (out_valid) begin
                if (out_re > 0) seen_pos = 1'b1;
                else if (seen_pos && out_re < 0) wrapped = 1'b1;
                r = int'(out_re);
            end
        end
        check("R7 step no wrap", !wrapped, int'(wrapped), 0);
        check("R7 step settles", r == 32767, r, 32767);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", WATCHDOG, 0);
        report();
    end

    initial begin
        t_reset();
        t_dc_and_rate();
        t_lane_alternate();
        t_half_cycle_offset();
        t_tone_mixdown();
        t_gaps_and_idle();
        t_saturation();
        report();
    end

endmodule